// File: doc/BRIEF.md
# Serial Control Register Interface

This block takes 25-bit control words from a three-wire serial port (strobe, shift clock and data) and keeps them in two register banks. The serial lines come from another clock domain. They are brought into the system clock domain by synchroniser chains, and their edges are detected there. A rising edge of the shift clock moves one data bit into a shift register. A rising edge of the strobe starts a short sequencer. The sequencer first captures the shift register into a holding word. A few cycles later it writes that word into the bank that the word's first bit selects.

The high bank holds phase, polarity and blanking settings, and every field of it becomes active when the word is written. The low bank holds integration-time and mode settings. Some of its fields are not active at once. They wait in a pending copy until a given horizontal line starts. The integration-mode bit waits for line 3. The shutter group waits for line 6 or line 234, or for line 12 when the sensor-type select is high. The line number and the line-start strobe come from a line counter outside this block. An asynchronous active-low all-clear returns every register to zero.

Top module: `sctl_regif`

## Requirements
- R1: Bit D00 is shifted in first and D24 last, one bit on each rising edge of `ser_sclk`. Output bit i of a bank (`lo_active` or `hi_active`) holds word bit D(i+1).
- R2: A new high-bank value is not visible at the 5th rising clock edge after `ser_stb` rises, counted with `ser_stb` driven midway between edges. It is visible from the 6th rising edge.
- R3: D00 = 0 writes the low bank and D00 = 1 writes the high bank. A word written to one bank leaves the other bank's outputs unchanged.
- R4: All 24 high-bank bits take their new value together, at the second sequencer pulse.
- R5: Low-bank bits 19, 21, 22 and 23 (mask 24'hE80000) take their new value at the second sequencer pulse.
- R6: Low-bank bit 20 (the integration-mode bit) takes its pending value only on a cycle where `hd_start` is high and `line_no` equals 3.
- R7: Low-bank bits 0 to 18 (the shutter group, mask 24'h07FFFF) take their pending value on an `hd_start` cycle whose `line_no` is 6 or 234 while `ccd_sel` is 0, or 12 while `ccd_sel` is 1. Any other line leaves them unchanged.
- R8: While `all_clr_n` is low, both banks, the pending copy, the shift register and the holding word are zero, whether or not the clock runs. A line event after the clear brings in no older value.
- R9: If more than 25 shift clocks come before a strobe, the last 25 bits shifted in form the word, and earlier bits are lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (18 MHz in the target system) |
| all_clr_n | input | 1 | Asynchronous all-clear, active low |
| ser_stb | input | 1 | Serial strobe, asynchronous |
| ser_sclk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| hd_start | input | 1 | One-cycle pulse at the start of a horizontal line |
| line_no | input | 10 | Number of the line that is starting |
| ccd_sel | input | 1 | Sensor-type select, chooses the shutter line set |
| lo_active | output | 24 | Active low-bank fields, bit i = D(i+1) |
| hi_active | output | 24 | Active high-bank fields, bit i = D(i+1) |

## Verification
The checker tests on every cycle the properties that can be seen at a single cycle. The high bank changes only after a second pulse for a word whose first bit is set, and it then holds exactly that word. The low bank's immediate bits follow the second pulse. The integration-mode bit and the shutter group hold still on every cycle that is not their qualifying line. The two pulses never overlap, and the outputs are zero while the all-clear is asserted. Some behaviour can only be shown by the bench's scenarios, because it depends on whole serial sequences: the mapping of bit order to positions, the exact cycle of the update measured from the raw strobe, the set of lines that depends on `ccd_sel`, the over-long word, and a clear that drops a pending value.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
   typedef enum logic {
      BANK_LO = 1'b0,
      BANK_HI = 1'b1
   } bank_e;

   localparam int unsigned DEF_WORD_W    = 25;
   localparam int unsigned DEF_SYNC_STG  = 2;
   localparam int unsigned DEF_LINE_W    = 10;
   localparam int unsigned DEF_SHUT_BITS = 19;
   localparam int unsigned DEF_INTEG_POS = 20;
endpackage

// File: rtl/sctl_sync.sv
// Multi-bit synchroniser chain; depth chosen by parameter.
module sctl_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   logic [WIDTH-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= '0;
               else        stg[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/sctl_front.sv
// Shift register on synchronised shift-clock rise, plus capture into holding word.
module sctl_front #(
   parameter int unsigned WORD_W = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              dat_s,
   input  logic              cap_en,
   output logic [WORD_W-1:0] dword
);
   logic              sclk_q;
   logic              sclk_rise;
   logic [WORD_W-1:0] shreg;
   logic [WORD_W-1:0] hold;

   assign sclk_rise = sclk_s & ~sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         shreg  <= '0;
         hold   <= '0;
      end else begin
         sclk_q <= sclk_s;
         if (sclk_rise) shreg <= {shreg[WORD_W-2:0], dat_s};
         if (cap_en)    hold  <= shreg;
      end
   end

   // First bit shifted sits at the top; present as dword[k] = D(k).
   generate
      for (genvar k = 0; k < WORD_W; k++) begin : g_rev
         assign dword[k] = hold[WORD_W-1-k];
      end
   endgenerate
endmodule

// File: rtl/sctl_seq.sv
// Strobe-triggered pulse sequencer: capture pulse then commit pulse.
module sctl_seq #(
   parameter int unsigned CAP_AT = 0,
   parameter int unsigned COM_AT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb_s,
   output logic cap_p,
   output logic com_p
);
   localparam int unsigned CW = $clog2(COM_AT + 1) > 0 ? $clog2(COM_AT + 1) : 1;

   logic          stb_q;
   logic          busy;
   logic [CW-1:0] cnt;
   logic          stb_rise;

   assign stb_rise = stb_s & ~stb_q;
   assign cap_p    = busy && (cnt == CW'(CAP_AT));
   assign com_p    = busy && (cnt == CW'(COM_AT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb_q <= 1'b0;
         busy  <= 1'b0;
         cnt   <= '0;
      end else begin
         stb_q <= stb_s;
         if (stb_rise) begin
            busy <= 1'b1;
            cnt  <= '0;
         end else if (busy) begin
            cnt <= cnt + 1'b1;
            if (com_p) busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sctl_banks.sv
// Two register banks; low bank has line-timed transfer groups.
module sctl_banks
   import sctl_pkg::*;
#(
   parameter int unsigned WORD_W     = 25,
   parameter int unsigned LINE_W     = 10,
   parameter int unsigned SHUT_BITS  = 19,
   parameter int unsigned INTEG_POS  = 20,
   parameter int unsigned LN_INTEG   = 3,
   parameter int unsigned LN_SHUT_A  = 6,
   parameter int unsigned LN_SHUT_B  = 234,
   parameter int unsigned LN_SHUT_C  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              com_p,
   input  logic [WORD_W-1:0] dword,
   input  logic              hd_start,
   input  logic [LINE_W-1:0] line_no,
   input  logic              ccd_sel,
   output logic [WORD_W-2:0] lo_act,
   output logic [WORD_W-2:0] hi_act
);
   localparam int unsigned PW = WORD_W - 1;
   localparam logic [PW-1:0] SHUT_M  = PW'((64'd1 << SHUT_BITS) - 64'd1);
   localparam logic [PW-1:0] INTEG_M = PW'(64'd1 << INTEG_POS);
   localparam logic [PW-1:0] NOW_M   = ~(SHUT_M | INTEG_M);

   bank_e         sel;
   logic [PW-1:0] payload;
   logic [PW-1:0] pend;
   logic [PW-1:0] lo_nxt;
   logic          integ_go;
   logic          shut_go;
   logic          lo_wr;
   logic          hi_wr;

   assign sel     = bank_e'(dword[0]);
   assign payload = dword[WORD_W-1:1];
   assign lo_wr   = com_p && (sel == BANK_LO);
   assign hi_wr   = com_p && (sel == BANK_HI);

   assign integ_go = hd_start && (line_no == LINE_W'(LN_INTEG));
   assign shut_go  = hd_start && (ccd_sel ? (line_no == LINE_W'(LN_SHUT_C))
                                          : ((line_no == LINE_W'(LN_SHUT_A)) ||
                                             (line_no == LINE_W'(LN_SHUT_B))));

   always_comb begin
      lo_nxt = lo_act;
      if (lo_wr)    lo_nxt = (lo_nxt & ~NOW_M)   | (payload & NOW_M);
      if (integ_go) lo_nxt = (lo_nxt & ~INTEG_M) | (pend & INTEG_M);
      if (shut_go)  lo_nxt = (lo_nxt & ~SHUT_M)  | (pend & SHUT_M);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend   <= '0;
         lo_act <= '0;
         hi_act <= '0;
      end else begin
         lo_act <= lo_nxt;
         if (lo_wr) pend   <= payload;
         if (hi_wr) hi_act <= payload;
      end
   end
endmodule

// File: rtl/sctl_regif.sv
module sctl_regif
   import sctl_pkg::*;
#(
   parameter int unsigned WORD_W    = DEF_WORD_W,
   parameter int unsigned SYNC_STG  = DEF_SYNC_STG,
   parameter int unsigned LINE_W    = DEF_LINE_W,
   parameter int unsigned SHUT_BITS = DEF_SHUT_BITS,
   parameter int unsigned INTEG_POS = DEF_INTEG_POS,
   parameter int unsigned CAP_AT    = 0,
   parameter int unsigned COM_AT    = 2,
   parameter int unsigned LN_INTEG  = 3,
   parameter int unsigned LN_SHUT_A = 6,
   parameter int unsigned LN_SHUT_B = 234,
   parameter int unsigned LN_SHUT_C = 12
) (
   input  logic              clk,
   input  logic              all_clr_n,
   input  logic              ser_stb,
   input  logic              ser_sclk,
   input  logic              ser_dat,
   input  logic              hd_start,
   input  logic [LINE_W-1:0] line_no,
   input  logic              ccd_sel,
   output logic [WORD_W-2:0] lo_active,
   output logic [WORD_W-2:0] hi_active
);
   // Elaboration-time parameter checks
   if (SYNC_STG < 2) begin : g_chk_sync
      $error("sctl_regif: SYNC_STG must be at least 2");
   end
   if (INTEG_POS >= WORD_W - 1 || SHUT_BITS > INTEG_POS) begin : g_chk_fld
      $error("sctl_regif: field layout does not fit the word");
   end
   if (COM_AT <= CAP_AT) begin : g_chk_seq
      $error("sctl_regif: commit pulse must follow capture pulse");
   end
   if ((64'd1 << LINE_W) <= 64'(LN_SHUT_B)) begin : g_chk_line
      $error("sctl_regif: LINE_W too narrow for line numbers");
   end

   logic [2:0]        sync_q;
   logic              stb_s;
   logic              sclk_s;
   logic              dat_s;
   logic              seq_cap;
   logic              seq_com;
   logic [WORD_W-1:0] cap_word;

   sctl_sync #(.WIDTH(3), .STAGES(SYNC_STG)) sync_i (
      .clk     (clk),
      .rst_n   (all_clr_n),
      .d_async ({ser_stb, ser_sclk, ser_dat}),
      .q_sync  (sync_q)
   );
   assign {stb_s, sclk_s, dat_s} = sync_q;

   sctl_seq #(.CAP_AT(CAP_AT), .COM_AT(COM_AT)) seq_i (
      .clk   (clk),
      .rst_n (all_clr_n),
      .stb_s (stb_s),
      .cap_p (seq_cap),
      .com_p (seq_com)
   );

   sctl_front #(.WORD_W(WORD_W)) front_i (
      .clk    (clk),
      .rst_n  (all_clr_n),
      .sclk_s (sclk_s),
      .dat_s  (dat_s),
      .cap_en (seq_cap),
      .dword  (cap_word)
   );

   sctl_banks #(
      .WORD_W(WORD_W), .LINE_W(LINE_W), .SHUT_BITS(SHUT_BITS),
      .INTEG_POS(INTEG_POS), .LN_INTEG(LN_INTEG), .LN_SHUT_A(LN_SHUT_A),
      .LN_SHUT_B(LN_SHUT_B), .LN_SHUT_C(LN_SHUT_C)
   ) banks_i (
      .clk      (clk),
      .rst_n    (all_clr_n),
      .com_p    (seq_com),
      .dword    (cap_word),
      .hd_start (hd_start),
      .line_no  (line_no),
      .ccd_sel  (ccd_sel),
      .lo_act   (lo_active),
      .hi_act   (hi_active)
   );
endmodule

// File: rtl/sctl_regif_chk.sv
module sctl_regif_chk #(
   parameter int unsigned WORD_W    = 25,
   parameter int unsigned LINE_W    = 10,
   parameter int unsigned SHUT_BITS = 19,
   parameter int unsigned INTEG_POS = 20,
   parameter int unsigned LN_INTEG  = 3,
   parameter int unsigned LN_SHUT_A = 6,
   parameter int unsigned LN_SHUT_B = 234,
   parameter int unsigned LN_SHUT_C = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cap_p,
   input logic              com_p,
   input logic [WORD_W-1:0] dword,
   input logic              hd_start,
   input logic [LINE_W-1:0] line_no,
   input logic              ccd_sel,
   input logic [WORD_W-2:0] lo_act,
   input logic [WORD_W-2:0] hi_act
);
   logic integ_line;
   logic shut_line;
   assign integ_line = hd_start && (line_no == LINE_W'(LN_INTEG));
   assign shut_line  = hd_start && (ccd_sel ? (line_no == LINE_W'(LN_SHUT_C))
                                            : ((line_no == LINE_W'(LN_SHUT_A)) ||
                                               (line_no == LINE_W'(LN_SHUT_B))));

   // R8: outputs cleared while all-clear asserted
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r8_clear_zero: assert (lo_act == '0 && hi_act == '0)
            else $error("R8 outputs not zero under all-clear");
      end
   end

   // R2: capture and commit pulses are distinct cycles
   a_r2_pulses_apart: assert property (@(posedge clk) disable iff (!rst_n)
      cap_p |-> !com_p);

   // R3/R4: high bank loads the selected word at commit
   a_r4_hi_load: assert property (@(posedge clk) disable iff (!rst_n)
      (com_p && dword[0]) |=> (hi_act == $past(dword[WORD_W-1:1])));

   // R3: high bank untouched without a high-bank commit
   a_r3_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(com_p && dword[0]) |=> $stable(hi_act));

   // R5: immediate low-bank bit follows commit
   a_r5_lo_now: assert property (@(posedge clk) disable iff (!rst_n)
      (com_p && !dword[0]) |=> (lo_act[WORD_W-2] == $past(dword[WORD_W-1])));

   // R6: integration-mode bit only moves on its line
   a_r6_integ_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !integ_line |=> $stable(lo_act[INTEG_POS]));

   // R7: shutter group only moves on its lines
   a_r7_shut_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !shut_line |=> $stable(lo_act[SHUT_BITS-1:0]));
endmodule

bind sctl_regif sctl_regif_chk #(
   .WORD_W(WORD_W), .LINE_W(LINE_W), .SHUT_BITS(SHUT_BITS),
   .INTEG_POS(INTEG_POS), .LN_INTEG(LN_INTEG), .LN_SHUT_A(LN_SHUT_A),
   .LN_SHUT_B(LN_SHUT_B), .LN_SHUT_C(LN_SHUT_C)
) chk_i (
   .clk      (clk),
   .rst_n    (all_clr_n),
   .cap_p    (seq_cap),
   .com_p    (seq_com),
   .dword    (cap_word),
   .hd_start (hd_start),
   .line_no  (line_no),
   .ccd_sel  (ccd_sel),
   .lo_act   (lo_active),
   .hi_act   (hi_active)
);

// File: tb/sctl_regif_tb_top.sv
module sctl_regif_tb_top;
   localparam logic [23:0] M_SHUT  = 24'h07FFFF;
   localparam logic [23:0] M_INTEG = 24'h100000;
   localparam logic [23:0] M_NOW   = 24'hE80000;

   logic        clk = 1'b0;
   logic        all_clr_n = 1'b0;
   logic        ser_stb = 1'b0;
   logic        ser_sclk = 1'b0;
   logic        ser_dat = 1'b0;
   logic        hd_start = 1'b0;
   logic [9:0]  line_no = '0;
   logic        ccd_sel = 1'b0;
   logic [23:0] lo_active;
   logic [23:0] hi_active;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #4 clk = ~clk;

   sctl_regif dut_i (
      .clk(clk), .all_clr_n(all_clr_n), .ser_stb(ser_stb), .ser_sclk(ser_sclk),
      .ser_dat(ser_dat), .hd_start(hd_start), .line_no(line_no), .ccd_sel(ccd_sel),
      .lo_active(lo_active), .hi_active(hi_active)
   );

   task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic shift_bit(input logic b);
      @(negedge clk); ser_dat = b;
      repeat (3) @(negedge clk);
      ser_sclk = 1'b1;
      repeat (3) @(negedge clk);
      ser_sclk = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   // Word vector d[k] = D(k); D00 = bank, D(i+1) = payload[i]
   task automatic shift_word(input logic bank, input logic [23:0] pl);
      shift_bit(bank);
      for (int i = 0; i < 24; i++) shift_bit(pl[i]);
   endtask

   task automatic strobe();
      @(negedge clk); ser_stb = 1'b1;
      repeat (8) @(negedge clk);
      ser_stb = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic line_evt(input int n);
      @(negedge clk); hd_start = 1'b1; line_no = 10'(n);
      @(negedge clk); hd_start = 1'b0; line_no = '0;
   endtask

   task automatic t_reset();
      chk("R8 reset lo", lo_active, 24'h0);
      chk("R8 reset hi", hi_active, 24'h0);
   endtask

   task automatic t_hi_timing();
      logic [23:0] pl = 24'hA5C3_96;
      shift_word(1'b1, pl);
      @(negedge clk); ser_stb = 1'b1;           // N0
      repeat (5) @(negedge clk);                // N5
      chk("R2 not yet at edge 5", hi_active, 24'h0);
      @(negedge clk);                           // N6
      chk("R2 R4 hi after edge 6", hi_active, pl);
      chk("R3 lo untouched by hi word", lo_active, 24'h0);
      repeat (3) @(negedge clk); ser_stb = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_bit_order();
      shift_word(1'b1, 24'h000001);
      strobe();
      chk("R1 D01 at bit 0", hi_active, 24'h000001);
      shift_word(1'b1, 24'h800000);
      strobe();
      chk("R1 D24 at bit 23", hi_active, 24'h800000);
   endtask

   task automatic t_lo_lines();
      logic [23:0] p = 24'h5AC3F7;
      logic [23:0] q = 24'h123456;
      logic [23:0] hi0 = hi_active;
      ccd_sel = 1'b0;
      shift_word(1'b0, p);
      strobe();
      chk("R5 immediate bits", lo_active, p & M_NOW);
      chk("R3 hi untouched by lo word", hi_active, hi0);
      line_evt(2);
      chk("R6 line 2 no effect", lo_active, p & M_NOW);
      line_evt(3);
      chk("R6 integ at line 3", lo_active, p & (M_NOW | M_INTEG));
      line_evt(12);
      chk("R7 line 12 ignored when sel=0", lo_active, p & (M_NOW | M_INTEG));
      line_evt(6);
      chk("R7 shutter at line 6", lo_active, p);
      shift_word(1'b0, q);
      strobe();
      chk("R5 second word immediate", lo_active, (q & M_NOW) | (p & ~M_NOW));
      line_evt(234);
      chk("R7 shutter at line 234", lo_active,
          (q & (M_NOW | M_SHUT)) | (p & M_INTEG));
      ccd_sel = 1'b1;
      shift_word(1'b0, p);
      strobe();
      line_evt(6);
      chk("R7 line 6 ignored when sel=1", lo_active,
          (p & M_NOW) | (q & M_SHUT) | (p & M_INTEG));
      line_evt(12);
      chk("R7 shutter at line 12 sel=1", lo_active, (p & (M_NOW | M_SHUT)) | (p & M_INTEG));
      ccd_sel = 1'b0;
   endtask

   task automatic t_long_word();
      logic [23:0] pl = 24'h3C0FF1;
      shift_bit(1'b1);                          // extra leading bit, lost
      shift_word(1'b1, pl);
      strobe();
      chk("R9 last 25 bits kept", hi_active, pl);
   endtask

   task automatic t_clear();
      shift_word(1'b0, 24'h0FFFFF);
      strobe();
      @(negedge clk); all_clr_n = 1'b0;
      #1;
      chk("R8 clear lo async", lo_active, 24'h0);
      chk("R8 clear hi async", hi_active, 24'h0);
      repeat (2) @(negedge clk); all_clr_n = 1'b1;
      line_evt(6);
      line_evt(3);
      chk("R8 pending dropped", lo_active, 24'h0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      all_clr_n = 1'b1;
      repeat (3) @(negedge clk);
      t_hi_timing();
      t_bit_order();
      t_lo_lines();
      t_long_word();
      t_clear();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end
endmodule